// File: doc/BRIEF.md
# Programmable Line-Period Divider

This block is the feedback counter of a line-locked pixel clock generator. It runs on the pixel clock and counts out one regenerated video line, whose length in pixel clocks is a 12-bit programmed value plus a fixed offset of 8. At the start of every line it emits a short active-high sync pulse, four clocks wide. It also produces a half-rate clock whose phase is pinned to the end of that pulse, so odd and even line lengths give the same half-clock phase where the pulse ends.

The programmed value is presented as a low byte and a high nibble. It is held in a working register that changes only on a reload strobe, which also restarts the line at count zero. A routing select chooses whether the sync output carries the regenerated pulse or an already conditioned external sync input. A feedback select chooses whether the line-start marker for the phase detector comes from the internal counter or from edges of an external divider input, with the active edge chosen by a polarity bit.

The counter is a two-state machine. `ST_PULSE` covers counts 0 to 3 and drives the regenerated pulse high. `ST_BODY` covers the rest of the line. The transitions are `T_PULSE_DONE` (`ST_PULSE` to `ST_BODY` at count 3), `T_LINE_WRAP` (`ST_BODY` to `ST_PULSE` at the last count, with the count going to 0) and `T_RELOAD` (any state to `ST_PULSE` at count 0 when the reload strobe is sampled).

Top module: `line_period_divider`

## Requirements
- R1: While reset (`rst_n` low) is asserted, the regenerated sync is high and `half_clk` equals `half_inv`. After reset the working value is 0xFFF, giving a line of 4103 clocks.
- R2: A line lasts exactly (working value + 8) clocks, with the working value = {`div_hi`, `div_lo`}. Regenerated pulses start every (working value + 8) clocks.
- R3: The regenerated sync is active high for exactly 4 clocks at counts 0 to 3 of each line, and low for the rest of the line.
- R4: Changes on `div_lo`/`div_hi` have no effect until `reload` is sampled high at a rising edge. In the clock after that edge the new value is in use and the line restarts at count 0, with the pulse high.
- R5: In the first clock after the regenerated pulse falls (count 4), the un-inverted half clock is 0. From there it alternates every clock until the next line starts, for both odd and even line lengths.
- R6: With `half_inv` = 1 the `half_clk` output is the bitwise inverse of the un-inverted half clock.
- R7: `sync_sel` = 0 routes the regenerated pulse to `sync_out`. `sync_sel` = 1 routes `sync_in` to `sync_out` in the same cycle, whatever the regenerated pulse is doing.
- R8: With `fb_sel` = 0, `fb_edge` is high for exactly one clock, at count 0 of each line. `ext_fb` has no effect on it.
- R9: With `fb_sel` = 1, `fb_edge` is high while `ext_fb` shows the selected edge against its value at the previous rising clock edge. `fb_pol` = 0 selects a 0-to-1 change and `fb_pol` = 1 selects a 1-to-0 change. The internal line start is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_lo | input | 8 | Low byte of the programmed line value |
| div_hi | input | 4 | High nibble of the programmed line value |
| reload | input | 1 | Loads the working value and restarts the line |
| sync_sel | input | 1 | 0: regenerated pulse to `sync_out`, 1: `sync_in` |
| sync_in | input | 1 | Conditioned external sync |
| fb_sel | input | 1 | 0: internal line start, 1: external feedback edges |
| fb_pol | input | 1 | External edge select, 0 rising, 1 falling |
| ext_fb | input | 1 | External divider output |
| half_inv | input | 1 | Inverts the half-rate clock |
| sync_out | output | 1 | Selected sync output |
| half_clk | output | 1 | Half-rate clock |
| fb_edge | output | 1 | Line-start marker for the phase detector |

## Verification
A reload sampled at one rising edge shows up in the following clock: count 0, pulse high and, with internal feedback, `fb_edge` high. Every later sync, half-clock and feedback result is then due at a fixed offset from that clock, modulo the line length. The half-clock phase is due in the first clock after the pulse falls. The sync routing and the external edge marker are combinational, so they are due in the same cycle the input changes. The bench drives every input on the falling edge and samples 1 ns later. It indexes every expected value by clocks since the last reload or reset release, so each check lands in the cycle where that result is due.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
    typedef enum logic {
        ST_BODY  = 1'b0,
        ST_PULSE = 1'b1
    } line_state_t;
endpackage

// File: rtl/lpd_line_counter.sv
module lpd_line_counter #(
    parameter int DIV_W   = 12,
    parameter int OFFSET  = 8,
    parameter int PULSE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_value,
    input  logic             reload,
    output logic             pulse_o,
    output logic             line_start_o,
    output logic             pulse_end_o
);
    import lpd_pkg::*;

    localparam int CNT_W = $clog2((1 << DIV_W) + OFFSET);

    line_state_t      st, st_nxt;
    logic [DIV_W-1:0] work_q;
    logic [CNT_W-1:0] cnt, cnt_nxt, last_cnt;

    assign last_cnt = CNT_W'(work_q) + CNT_W'(OFFSET - 1);

    // Next-state logic: T_PULSE_DONE, T_LINE_WRAP, T_RELOAD
    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt + 1'b1;
        if (reload) begin
            st_nxt  = ST_PULSE;                     // T_RELOAD
            cnt_nxt = '0;
        end else begin
            unique case (st)
                ST_PULSE: if (cnt == CNT_W'(PULSE_W - 1)) st_nxt = ST_BODY;  // T_PULSE_DONE
                ST_BODY:  if (cnt == last_cnt) begin                         // T_LINE_WRAP
                              st_nxt  = ST_PULSE;
                              cnt_nxt = '0;
                          end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_PULSE;
            cnt    <= '0;
            work_q <= '1;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
            if (reload) work_q <= div_value;
        end
    end

    // Outputs
    always_comb begin
        pulse_o      = (st == ST_PULSE);
        line_start_o = (cnt == '0);
        pulse_end_o  = (st == ST_PULSE) && (st_nxt == ST_BODY);
    end

    p_cnt_in_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last_cnt);
    p_pulse_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PULSE) == (cnt < CNT_W'(PULSE_W)));
    p_work_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> $stable(work_q));
    p_reload_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt == '0 && st == ST_PULSE));
endmodule

// File: rtl/lpd_half_rate.sv
module lpd_half_rate (
    input  logic clk,
    input  logic rst_n,
    input  logic realign,
    input  logic inv,
    output logic half_o
);
    logic half_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       half_q <= 1'b0;
        else if (realign) half_q <= 1'b0;
        else              half_q <= ~half_q;
    end

    assign half_o = half_q ^ inv;

    p_half_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !realign |=> (half_q != $past(half_q)));
endmodule

// File: rtl/lpd_fb_select.sv
module lpd_fb_select (
    input  logic clk,
    input  logic rst_n,
    input  logic fb_sel,
    input  logic fb_pol,
    input  logic ext_fb,
    input  logic line_start,
    output logic fb_edge
);
    logic ext_prev, ext_rise, ext_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_prev <= 1'b0;
        else        ext_prev <= ext_fb;
    end

    always_comb begin
        ext_rise = ext_fb & ~ext_prev;
        ext_fall = ~ext_fb & ext_prev;
        if (fb_sel) fb_edge = fb_pol ? ext_fall : ext_rise;
        else        fb_edge = line_start;
    end

    p_ext_edge_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_sel && fb_edge) |=> (!fb_edge || !fb_sel || (fb_pol != $past(fb_pol))));
endmodule

// File: rtl/line_period_divider.sv
module line_period_divider #(
    parameter int DIV_W   = 12,
    parameter int LO_W    = 8,
    parameter int OFFSET  = 8,
    parameter int PULSE_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LO_W-1:0]       div_lo,
    input  logic [DIV_W-LO_W-1:0] div_hi,
    input  logic                  reload,
    input  logic                  sync_sel,
    input  logic                  sync_in,
    input  logic                  fb_sel,
    input  logic                  fb_pol,
    input  logic                  ext_fb,
    input  logic                  half_inv,
    output logic                  sync_out,
    output logic                  half_clk,
    output logic                  fb_edge
);
    logic regen_pulse, line_start, pulse_end;

    lpd_line_counter #(
        .DIV_W  (DIV_W),
        .OFFSET (OFFSET),
        .PULSE_W(PULSE_W)
    ) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .div_value   ({div_hi, div_lo}),
        .reload      (reload),
        .pulse_o     (regen_pulse),
        .line_start_o(line_start),
        .pulse_end_o (pulse_end)
    );

    lpd_half_rate u_half (
        .clk    (clk),
        .rst_n  (rst_n),
        .realign(pulse_end),
        .inv    (half_inv),
        .half_o (half_clk)
    );

    lpd_fb_select u_fb (
        .clk       (clk),
        .rst_n     (rst_n),
        .fb_sel    (fb_sel),
        .fb_pol    (fb_pol),
        .ext_fb    (ext_fb),
        .line_start(line_start),
        .fb_edge   (fb_edge)
    );

    assign sync_out = sync_sel ? sync_in : regen_pulse;

    p_line_edge_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fb_sel && fb_edge && !reload) |=> (fb_sel || !fb_edge));
endmodule

// File: tb/line_period_divider_tb.sv
module line_period_divider_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_lo = '0;
    logic [3:0] div_hi = '0;
    logic       reload = 1'b0, sync_sel = 1'b0, sync_in = 1'b0;
    logic       fb_sel = 1'b0, fb_pol = 1'b0, ext_fb = 1'b0, half_inv = 1'b0;
    logic       sync_out, half_clk, fb_edge;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    line_period_divider u_dut (
        .clk(clk), .rst_n(rst_n), .div_lo(div_lo), .div_hi(div_hi),
        .reload(reload), .sync_sel(sync_sel), .sync_in(sync_in),
        .fb_sel(fb_sel), .fb_pol(fb_pol), .ext_fb(ext_fb),
        .half_inv(half_inv), .sync_out(sync_out), .half_clk(half_clk),
        .fb_edge(fb_edge)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Call at a falling edge; on return the DUT shows count 0 of the new line.
    task automatic do_reload(input int val);
        div_lo = val[7:0];
        div_hi = val[11:8];
        reload = 1'b1;
        @(negedge clk);
        reload = 1'b0;
    endtask

    // Samples `cycles` clocks starting at count 0 of a line of length n.
    task automatic run_check(input int n, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            int k;
            #1;
            k = i % n;
            chk("R2/R3 sync", sync_out, (k < 4));
            if (k >= 4)
                chk(half_inv ? "R6 half inverted" : "R5 half phase",
                    half_clk, logic'((k - 4) % 2) ^ half_inv);
            if (!fb_sel) chk("R8 line edge", fb_edge, (k == 0));
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        chk("R1 sync in reset", sync_out, 1'b1);
        chk("R1 half in reset", half_clk, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        run_check(4103, 4110);   // R1 default 0xFFF + 8
    endtask

    task automatic t_lengths();
        do_reload(0);      run_check(8, 24);     // R2 shortest, even
        do_reload(5);      run_check(13, 39);    // R2 odd
        do_reload(12);     run_check(20, 40);    // R2 even
        do_reload(12'h100); run_check(264, 530); // R2 high nibble
    endtask

    task automatic t_inv();
        half_inv = 1'b1;
        do_reload(5);  run_check(13, 39);        // R6 odd
        do_reload(6);  run_check(14, 28);        // R6 even
        half_inv = 1'b0;
    endtask

    task automatic t_hold_reload();
        do_reload(0);
        div_lo = 8'd12;                          // R4 no reload yet
        run_check(8, 24);
        run_check(8, 5);                         // stop mid-line
        do_reload(12);                           // R4 restart
        run_check(20, 44);
    endtask

    task automatic t_sync_route();
        do_reload(0);
        sync_sel = 1'b1;
        sync_in  = 1'b0;
        #1 chk("R7 sync_in low over pulse", sync_out, 1'b0);
        repeat (6) @(negedge clk);
        sync_in = 1'b1;
        #1 chk("R7 sync_in high in body", sync_out, 1'b1);
        @(negedge clk);
        sync_in  = 1'b0;
        sync_sel = 1'b0;
        #1 chk("R7 regen routed back", sync_out, 1'b0);
        @(negedge clk);
    endtask

    task automatic t_ext_ignored();
        do_reload(0);
        #1 chk("R8 edge at count 0", fb_edge, 1'b1);
        for (int i = 1; i < 8; i++) begin
            @(negedge clk);
            ext_fb = ~ext_fb;
            #1 chk("R8 ext_fb ignored", fb_edge, 1'b0);
        end
        @(negedge clk);
        #1 chk("R8 edge next line", fb_edge, 1'b1);
        ext_fb = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_ext_edges();
        fb_sel = 1'b1;
        fb_pol = 1'b0;
        do_reload(0);
        #1 chk("R9 internal start ignored", fb_edge, 1'b0);
        @(negedge clk);
        ext_fb = 1'b1;
        #1 chk("R9 rising edge", fb_edge, 1'b1);
        @(negedge clk);
        #1 chk("R9 rising one clock", fb_edge, 1'b0);
        ext_fb = 1'b0;
        #1 chk("R9 falling ignored pol0", fb_edge, 1'b0);
        @(negedge clk);
        fb_pol = 1'b1;
        ext_fb = 1'b1;
        #1 chk("R9 rising ignored pol1", fb_edge, 1'b0);
        @(negedge clk);
        ext_fb = 1'b0;
        #1 chk("R9 falling edge", fb_edge, 1'b1);
        @(negedge clk);
        #1 chk("R9 falling one clock", fb_edge, 1'b0);
        fb_sel = 1'b0;
        fb_pol = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(64'd200000 * 20);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_lengths();
        t_inv();
        t_hold_reload();
        t_sync_route();
        t_ext_ignored();
        t_ext_edges();
        summary();
        $finish;
    end
endmodule